// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block is the bit-manipulation datapath of an 8-bit controller. It works on one addressable bit at a time together with the carry flag, which serves as a one-bit accumulator. Each cycle in which `op_valid` is high it takes an operation code, the present value of the addressed bit and the present carry. One clock later it presents the new carry, the value to write back to the bit with a write strobe, and a branch-taken signal for the bit and carry test jumps.

Mapping a bit address to a byte and a position happens outside the block. The block is told only whether the addressed byte is the flag byte and which bit position inside the byte is addressed. A parameterised mask then blocks writes to the read-only flag positions: parity, overflow and auxiliary carry.

All outputs are registered. Carry is passed through unchanged for every operation that does not target it, so the surrounding core can always load `carry_out` back into its flag register.

Top module: `bool_bit_proc`

## Requirements
- R1: After reset, and until the first accepted operation, `res_valid`, `carry_out`, `bit_out`, `bit_we` and `branch_taken` are all 0.
- R2: An operation presented with `op_valid`=1 produces its result on the outputs after exactly one rising clock edge, with `res_valid`=1. A cycle with `op_valid`=0 produces `res_valid`=0, `bit_we`=0 and `branch_taken`=0 on the following cycle.
- R3: Carry operations clear (code 1), set (code 2) and complement (code 3) the carry. They never assert `bit_we` or `branch_taken`.
- R4: Bit operations clear (code 4), set (code 5) and complement (code 6) the addressed bit. They assert `bit_we` with the new value on `bit_out`, and `carry_out` equals the input carry.
- R5: The logic-into-carry operations give `carry_out` = C AND B (code 7), C AND NOT B (code 8), C OR B (code 9) or C OR NOT B (code 10). None of them writes the bit.
- R6: Code 11 copies the bit into carry with no bit write. Code 12 writes carry into the bit (`bit_we`=1, `bit_out`=carry) and leaves carry unchanged.
- R7: Jump-if-bit-set (code 13) takes the branch when the bit is 1, and jump-if-bit-clear (code 14) takes it when the bit is 0. Neither writes the bit or changes carry.
- R8: Jump-if-set-then-clear (code 15) takes the branch only when the bit is 1, and in that case writes 0 to the bit. When the bit is 0 it neither branches nor writes.
- R9: Jump-on-carry (code 16) takes the branch when carry is 1, and jump-on-no-carry (code 17) takes it when carry is 0. Neither writes the bit or changes carry.
- R10: When `flag_sel`=1 and `bit_pos` is a protected position (default mask 8'b0100_0101: bits 0, 2 and 6), `bit_we` stays 0 for every operation. The carry result and the branch decision are not affected.
- R11: Code 0 and the unused codes 18 to 31 do nothing: `bit_we`=0, `branch_taken`=0 and `carry_out` equals the input carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| bit_val | input | 1 | Current value of the addressed bit |
| carry_in | input | 1 | Current carry flag |
| flag_sel | input | 1 | Addressed bit lies in the flag byte |
| bit_pos | input | 3 | Bit position inside the addressed byte |
| res_valid | output | 1 | Result of the previous cycle's operation |
| carry_out | output | 1 | New carry flag |
| bit_out | output | 1 | Value to write into the addressed bit |
| bit_we | output | 1 | Write strobe for the addressed bit |
| branch_taken | output | 1 | Test jump condition is satisfied |

## Verification
Every piece of internal state sits in one output register, so a wrong next-state term shows on the ports on the very next cycle as a wrong carry, a spurious or missing write strobe, or a wrong branch flag. The bench therefore checks every code against every combination of bit value, carry, flag-byte select and bit position, one cycle after each operation. A missing protection term shows up as a write strobe at positions 0, 2 or 6 of the flag byte. A write that is not gated on the tested bit in jump-if-set-then-clear shows up as a strobe whenever the bit is 0.

// File: rtl/bbp_pkg.sv
package bbp_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP        = 5'd0,
        OP_CY_CLR     = 5'd1,
        OP_CY_SET     = 5'd2,
        OP_CY_INV     = 5'd3,
        OP_B_CLR      = 5'd4,
        OP_B_SET      = 5'd5,
        OP_B_INV      = 5'd6,
        OP_AND_B      = 5'd7,
        OP_AND_NB     = 5'd8,
        OP_OR_B       = 5'd9,
        OP_OR_NB      = 5'd10,
        OP_CY_LOAD    = 5'd11,
        OP_B_STORE    = 5'd12,
        OP_BR_SET     = 5'd13,
        OP_BR_CLR     = 5'd14,
        OP_BR_SET_ZAP = 5'd15,
        OP_BR_CY      = 5'd16,
        OP_BR_NCY     = 5'd17
    } op_e;

    typedef struct packed {
        logic vld;
        logic cy;
        logic bv;
        logic we;
        logic tk;
    } res_t;
endpackage

// File: rtl/bbp_logic.sv
module bbp_logic
    import bbp_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            bit_in,
    input  logic            cy_in,
    output logic            cy_nxt,
    output logic            bit_nxt,
    output logic            wr_req,
    output logic            take
);
    always_comb begin
        cy_nxt  = cy_in;
        bit_nxt = bit_in;
        wr_req  = 1'b0;
        take    = 1'b0;
        case (op)
            OP_CY_CLR:     cy_nxt = 1'b0;
            OP_CY_SET:     cy_nxt = 1'b1;
            OP_CY_INV:     cy_nxt = ~cy_in;
            OP_B_CLR:      begin bit_nxt = 1'b0;    wr_req = 1'b1; end
            OP_B_SET:      begin bit_nxt = 1'b1;    wr_req = 1'b1; end
            OP_B_INV:      begin bit_nxt = ~bit_in; wr_req = 1'b1; end
            OP_AND_B:      cy_nxt = cy_in & bit_in;
            OP_AND_NB:     cy_nxt = cy_in & ~bit_in;
            OP_OR_B:       cy_nxt = cy_in | bit_in;
            OP_OR_NB:      cy_nxt = cy_in | ~bit_in;
            OP_CY_LOAD:    cy_nxt = bit_in;
            OP_B_STORE:    begin bit_nxt = cy_in;   wr_req = 1'b1; end
            OP_BR_SET:     take = bit_in;
            OP_BR_CLR:     take = ~bit_in;
            OP_BR_SET_ZAP: begin
                take    = bit_in;
                wr_req  = bit_in;
                bit_nxt = 1'b0;
            end
            OP_BR_CY:      take = cy_in;
            OP_BR_NCY:     take = ~cy_in;
            default:       ;
        endcase
    end
endmodule

// File: rtl/bbp_guard.sv
module bbp_guard #(
    parameter int               BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] RO_MASK = 8'b0100_0101,
    localparam int              SEL_W   = $clog2(BYTE_W)
) (
    input  logic             in_flags,
    input  logic [SEL_W-1:0] pos,
    input  logic             wr_req,
    output logic             wr_ok
);
    logic locked;

    always_comb begin
        locked = in_flags & RO_MASK[pos];
        wr_ok  = wr_req & ~locked;
    end
endmodule

// File: rtl/bool_bit_proc.sv
module bool_bit_proc
    import bbp_pkg::*;
#(
    parameter int               BYTE_W  = 8,
    parameter logic [BYTE_W-1:0] RO_MASK = 8'b0100_0101,
    localparam int              SEL_W   = $clog2(BYTE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             bit_val,
    input  logic             carry_in,
    input  logic             flag_sel,
    input  logic [SEL_W-1:0] bit_pos,
    output logic             res_valid,
    output logic             carry_out,
    output logic             bit_out,
    output logic             bit_we,
    output logic             branch_taken
);
    logic cy_nxt, bit_nxt, wr_req, take, wr_ok;
    res_t res_d, res_q;

    bbp_logic u_logic (
        .op      (op_code),
        .bit_in  (bit_val),
        .cy_in   (carry_in),
        .cy_nxt  (cy_nxt),
        .bit_nxt (bit_nxt),
        .wr_req  (wr_req),
        .take    (take)
    );

    bbp_guard #(.BYTE_W(BYTE_W), .RO_MASK(RO_MASK)) u_guard (
        .in_flags (flag_sel),
        .pos      (bit_pos),
        .wr_req   (wr_req),
        .wr_ok    (wr_ok)
    );

    always_comb begin
        res_d     = '0;
        res_d.vld = op_valid;
        res_d.cy  = res_q.cy;
        res_d.bv  = res_q.bv;
        if (op_valid) begin
            res_d.cy = cy_nxt;
            res_d.bv = bit_nxt;
            res_d.we = wr_ok;
            res_d.tk = take;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid    = res_q.vld;
    assign carry_out    = res_q.cy;
    assign bit_out      = res_q.bv;
    assign bit_we       = res_q.we;
    assign branch_taken = res_q.tk;

    // R2: idle cycles give no strobe and no branch on the next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !bit_we && !branch_taken));

    // R3: carry-only operations never write the bit
    a_r3_carry_ops_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= OP_CY_CLR && op_code <= OP_CY_INV) |=> !bit_we);

    // R4: bit operations carry the input carry through
    a_r4_bit_ops_keep_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= OP_B_CLR && op_code <= OP_B_INV)
        |=> (carry_out == $past(carry_in)));

    // R8: a clear bit under jump-if-set-then-clear gives no write and no branch
    a_r8_zap_needs_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_BR_SET_ZAP && !bit_val) |=> (!bit_we && !branch_taken));

    // R10: protected flag positions are never strobed
    a_r10_ro_flag_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_sel && RO_MASK[bit_pos]) |=> !bit_we);

    // R11: unused codes leave carry alone
    a_r11_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > OP_BR_NCY)
        |=> (!bit_we && !branch_taken && carry_out == $past(carry_in)));
endmodule

// File: tb/sim_bool_bit_proc.sv
module sim_bool_bit_proc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic       bit_val = 1'b0;
    logic       carry_in = 1'b0;
    logic       flag_sel = 1'b0;
    logic [2:0] bit_pos = '0;
    logic       res_valid, carry_out, bit_out, bit_we, branch_taken;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [7:0] RO = 8'b0100_0101;

    always #10 clk = ~clk;

    bool_bit_proc u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_val(bit_val), .carry_in(carry_in), .flag_sel(flag_sel),
        .bit_pos(bit_pos), .res_valid(res_valid), .carry_out(carry_out),
        .bit_out(bit_out), .bit_we(bit_we), .branch_taken(branch_taken)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%0d b=%0b c=%0b f=%0b p=%0d act=%b exp=%b",
                     tag, op_code, bit_val, carry_in, flag_sel, bit_pos, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        if (op >= 1 && op <= 3)   return "R3";
        if (op >= 4 && op <= 6)   return "R4";
        if (op >= 7 && op <= 10)  return "R5";
        if (op == 11 || op == 12) return "R6";
        if (op == 13 || op == 14) return "R7";
        if (op == 15)             return "R8";
        if (op == 16 || op == 17) return "R9";
        return "R11";
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", {res_valid, carry_out, bit_out, bit_we, branch_taken}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {res_valid, carry_out, bit_out, bit_we, branch_taken}, 5'b0);

        for (int op = 0; op < 32; op++) begin
            for (int b = 0; b < 2; b++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int f = 0; f < 2; f++) begin
                        for (int p = 0; p < 8; p++) begin
                            logic ec, eb, ew, et, wr, prot;
                            ec = c[0]; eb = b[0]; wr = 1'b0; et = 1'b0;
                            case (op)
                                1: ec = 1'b0;
                                2: ec = 1'b1;
                                3: ec = ~c[0];
                                4: begin eb = 1'b0; wr = 1'b1; end
                                5: begin eb = 1'b1; wr = 1'b1; end
                                6: begin eb = ~b[0]; wr = 1'b1; end
                                7: ec = c[0] & b[0];
                                8: ec = c[0] & ~b[0];
                                9: ec = c[0] | b[0];
                                10: ec = c[0] | ~b[0];
                                11: ec = b[0];
                                12: begin eb = c[0]; wr = 1'b1; end
                                13: et = b[0];
                                14: et = ~b[0];
                                15: begin et = b[0]; wr = b[0]; eb = 1'b0; end
                                16: et = c[0];
                                17: et = ~c[0];
                                default: ;
                            endcase
                            prot = (f == 1) && RO[p];
                            ew = wr && !prot;
                            op_code  = op[4:0];
                            bit_val  = b[0];
                            carry_in = c[0];
                            flag_sel = f[0];
                            bit_pos  = p[2:0];
                            op_valid = 1'b1;
                            @(negedge clk);
                            // R2: one-cycle latency, valid flag set
                            chk("R2", {4'b0, res_valid}, 5'b1);
                            chk(prot && wr ? "R10" : tag_of(op),
                                {1'b0, carry_out, bit_we, branch_taken, (ew ? bit_out : 1'b0)},
                                {1'b0, ec, ew, et, (ew ? eb : 1'b0)});
                        end
                    end
                end
            end
        end

        // R2: idle cycle after activity gives no strobe or branch
        op_code = 5'd15; bit_val = 1'b1; op_valid = 1'b0;
        @(negedge clk);
        chk("R2", {2'b0, res_valid, bit_we, branch_taken}, 5'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule